// File: doc/BRIEF.md
# Past-Qualified Compare System Timer

This block is a free-running system timer whose count advances once per 250 ns tick, derived from the system clock by a fixed prescaler. Four compare channels sit on the count. Software writes each channel a target, given either in 250 ns ticks or in whole microseconds. The block then raises a one-cycle event and a sticky flag when the count reaches that target.

Every target is checked at the moment it is written. A target that lies a short, bounded distance behind the current count is treated as already due, and the channel fires on the next clock. Without this check, such a target would have to wait for the 32-bit count to wrap all the way around. Targets outside that window are armed and fire on the first matching count, after which the channel goes idle until its next write.

The count can be re-aligned to a real-time counter by a one-cycle load strobe carrying a value in 250 ns units. Armed channels are checked again against the loaded value, so a jump forward past a target fires it at once.

Top module: `stm_timer`

## Requirements
- R1: While reset is low, and on the first cycle after it is released, `now_ticks` is 0 and every `evt_pulse` and `evt_flag` bit is 0.
- R2: `now_ticks` advances by exactly 1 once every `TICK_DIV` clocks. After 2^32-1 it wraps to 0.
- R3: A write with `cmp_us`=0 takes the full 32-bit value as a target in 250 ns ticks, matched against `now_ticks`. A write with `cmp_us`=1 takes bits [29:0] as a target in microseconds, matched against `now_ticks[31:2]`.
- R4: On a 250 ns write, if (now_ticks − target) mod 2^32 is below `WIN_Q`, the channel pulses on the clock after the write. A target equal to the current count counts as past.
- R5: On a microsecond write, if (now_ticks[31:2] − target) mod 2^30 is below `WIN_US`, the channel pulses on the clock after the write.
- R6: A target outside its window is armed. `evt_pulse` rises one clock after the first cycle in which the count matches the target.
- R7: After firing, a channel is disarmed and gives no further pulse until it is written again.
- R8: A `sync_ld` strobe makes `now_ticks` equal `sync_val` on the next clock. The tick phase restarts, so the next increment comes `TICK_DIV` clocks later.
- R9: After a load, an armed channel whose target lies within its window of the loaded count pulses one clock after the loaded count appears. A channel whose target is still ahead stays armed.
- R10: `evt_flag` is set with every pulse and holds until `flag_clr` is driven high for that channel. A fire in the same cycle as a clear wins.
- R11: Writes, clears and fires on one channel leave the other channels' pulses and flags untouched.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | System clock |
| rst_n | input | 1 | Synchronous reset, active low |
| sync_ld | input | 1 | Load strobe for re-alignment to the real-time counter |
| sync_val | input | 32 | Count to load, in 250 ns units |
| cmp_wr | input | 4 | Per-channel target write strobe |
| cmp_us | input | 4 | Per-channel unit select: 1 = microseconds, 0 = 250 ns |
| cmp_tgt | input | 128 | Per-channel target; channel i uses bits [32i+31:32i] |
| flag_clr | input | 4 | Per-channel clear of the sticky flag (write 1 to clear) |
| evt_pulse | output | 4 | One-cycle event per channel |
| evt_flag | output | 4 | Sticky event flag per channel |
| now_ticks | output | 32 | Current count in 250 ns ticks |

## Verification
The bench probes both window edges in both units: one unit inside the window must fire on the next clock, and exactly the window distance must arm instead. An off-by-one comparison would either fire a far-future target or leave a just-passed one waiting a full wrap. It checks that a microsecond target fires once, on the first of the four ticks that match, not on each of them. It also checks that a target behind a wrapped count fires only after the wrap. Load strobes are aimed both past and short of armed targets; a design that skipped re-evaluation would miss the jumped-over event, and one that re-evaluated too freely would fire the target still ahead.

// File: rtl/stm_pkg.sv
// Package: shared constants and helpers for the system timer.
// Assumes the count is at least 3 bits wide so a microsecond view exists.
package stm_pkg;
    // Unit select values carried on the per-channel unit input
    localparam logic UNIT_Q  = 1'b0;   // 250 ns ticks
    localparam logic UNIT_US = 1'b1;   // 1 us (four ticks)
    // Ticks per microsecond expressed as a shift
    localparam int US_SHIFT = 2;
endpackage

// File: rtl/stm_tick_gen.sv
// Module: stm_tick_gen
// Divides the system clock into a one-cycle tick every TICK_DIV clocks.
// A restart strobe clears the phase so the next tick is a full period away.
// Assumes TICK_DIV >= 1; TICK_DIV == 1 ticks on every clock.
module stm_tick_gen #(
    parameter int TICK_DIV = 4
) (
    input  logic clk,
    input  logic rst_n,
    input  logic restart,
    output logic tick
);
    generate
        if (TICK_DIV == 1) begin : g_direct
            // No division needed: every clock is a tick
            assign tick = 1'b1;
        end else begin : g_div
            localparam int DIV_W = $clog2(TICK_DIV);
            localparam logic [DIV_W-1:0] DIV_LAST = DIV_W'(TICK_DIV - 1);
            logic [DIV_W-1:0] phase;

            assign tick = (phase == DIV_LAST) && !restart;

            // Phase counter: wraps at the divide ratio, cleared on restart
            always_ff @(posedge clk) begin
                if (!rst_n || restart || phase == DIV_LAST) begin
                    phase <= '0;
                end else begin
                    phase <= phase + 1'b1;
                end
            end

            // R2: phase never leaves its range
            p_phase_range_r2: assert property (@(posedge clk) disable iff (!rst_n)
                phase <= DIV_LAST);
            // R8: a restart always puts the phase back to zero
            p_restart_phase_r8: assert property (@(posedge clk) disable iff (!rst_n)
                restart |=> phase == '0);
        end
    endgenerate
endmodule

// File: rtl/stm_counter.sv
// Module: stm_counter
// Holds the free-running count in 250 ns ticks. It loads an external value
// on a sync strobe and flags the following cycle for channel re-evaluation.
// Assumes the sync strobe is a single-cycle pulse.
module stm_counter #(
    parameter int CNT_W = 32
) (
    input  logic             clk,
    input  logic             rst_n,
    input  logic             tick,
    input  logic             sync_ld,
    input  logic [CNT_W-1:0] sync_val,
    output logic [CNT_W-1:0] count,
    output logic             reeval
);
    // Count register: load wins over increment; increment wraps mod 2^CNT_W
    always_ff @(posedge clk) begin
        if (!rst_n) begin
            count <= '0;
        end else if (sync_ld) begin
            count <= sync_val;
        end else if (tick) begin
            count <= count + 1'b1;
        end
    end

    // Re-evaluation marker: high in the first cycle the loaded value is visible
    always_ff @(posedge clk) begin
        if (!rst_n) begin
            reeval <= 1'b0;
        end else begin
            reeval <= sync_ld;
        end
    end

    // R2: a tick without a load steps the count by one
    p_count_step_r2: assert property (@(posedge clk) disable iff (!rst_n)
        (tick && !sync_ld) |=> count == $past(count) + 1'b1);
    // R2: no tick and no load leaves the count alone
    p_count_hold_r2: assert property (@(posedge clk) disable iff (!rst_n)
        (!tick && !sync_ld) |=> $stable(count));
    // R8: a load shows the loaded value on the next cycle
    p_sync_load_r8: assert property (@(posedge clk) disable iff (!rst_n)
        sync_ld |=> count == $past(sync_val));
endmodule

// File: rtl/stm_channel.sv
// Module: stm_channel
// One compare channel. A written target is tested against a recent-past
// window in its own units and either fires on the next clock or is armed.
// An armed target fires on first match, or at a re-evaluation if the loaded
// count has passed it within the window. Firing disarms the channel.
// Assumes WIN_Q < 2^CNT_W and WIN_US < 2^(CNT_W-2).
module stm_channel
    import stm_pkg::*;
#(
    parameter int CNT_W  = 32,
    parameter int WIN_Q  = 4194304,
    parameter int WIN_US = 4294967
) (
    input  logic             clk,
    input  logic             rst_n,
    input  logic [CNT_W-1:0] now,
    input  logic             reeval,
    input  logic             wr_en,
    input  logic             wr_us,
    input  logic [CNT_W-1:0] wr_tgt,
    input  logic             clr,
    output logic             pulse,
    output logic             flag
);
    localparam int US_W = CNT_W - US_SHIFT;
    localparam logic [CNT_W-1:0] WIN_Q_V  = CNT_W'(WIN_Q);
    localparam logic [US_W-1:0]  WIN_US_V = US_W'(WIN_US);

    logic [US_W-1:0]  now_us;
    logic             armed;
    logic             arm_us;
    logic [CNT_W-1:0] arm_tgt;
    logic [CNT_W-1:0] wr_diff_q;
    logic [US_W-1:0]  wr_diff_us;
    logic [CNT_W-1:0] arm_diff_q;
    logic [US_W-1:0]  arm_diff_us;
    logic             wr_past;
    logic             arm_past;
    logic             arm_match;
    logic             fire;

    assign now_us = now[CNT_W-1:US_SHIFT];

    // Window test for the target being written now
    always_comb begin
        wr_diff_q  = now - wr_tgt;
        wr_diff_us = now_us - wr_tgt[US_W-1:0];
        wr_past    = (wr_us == UNIT_US) ? (wr_diff_us < WIN_US_V) : (wr_diff_q < WIN_Q_V);
    end

    // Match and window test for the stored, armed target
    always_comb begin
        arm_diff_q  = now - arm_tgt;
        arm_diff_us = now_us - arm_tgt[US_W-1:0];
        arm_past    = (arm_us == UNIT_US) ? (arm_diff_us < WIN_US_V) : (arm_diff_q < WIN_Q_V);
        arm_match   = (arm_us == UNIT_US) ? (now_us == arm_tgt[US_W-1:0]) : (now == arm_tgt);
    end

    // Fire decision: a write takes priority over the old armed target
    always_comb begin
        if (wr_en) begin
            fire = wr_past;
        end else begin
            fire = armed && (arm_match || (reeval && arm_past));
        end
    end

    // Target storage and arm state
    always_ff @(posedge clk) begin
        if (!rst_n) begin
            armed   <= 1'b0;
            arm_us  <= UNIT_Q;
            arm_tgt <= '0;
        end else if (wr_en) begin
            armed   <= !wr_past;
            arm_us  <= wr_us;
            arm_tgt <= wr_tgt;
        end else if (fire) begin
            armed   <= 1'b0;
        end
    end

    // Event pulse: one clock per fire
    always_ff @(posedge clk) begin
        if (!rst_n) begin
            pulse <= 1'b0;
        end else begin
            pulse <= fire;
        end
    end

    // Sticky flag: set by a fire, cleared by a write of one; set wins
    always_ff @(posedge clk) begin
        if (!rst_n) begin
            flag <= 1'b0;
        end else begin
            flag <= fire || (flag && !clr);
        end
    end

    // R4: a tick-unit write inside the window fires on the next clock
    p_imm_fire_r4: assert property (@(posedge clk) disable iff (!rst_n)
        (wr_en && wr_us == UNIT_Q && (now - wr_tgt) < WIN_Q_V) |=> pulse);
    // R5: a microsecond write inside the window fires on the next clock
    p_imm_fire_r5: assert property (@(posedge clk) disable iff (!rst_n)
        (wr_en && wr_us == UNIT_US && (now_us - wr_tgt[US_W-1:0]) < WIN_US_V) |=> pulse);
    // R7: a pulse is never followed by another unless a new write came in
    p_one_shot_r7: assert property (@(posedge clk) disable iff (!rst_n)
        (pulse && !wr_en) |=> !pulse);
    // R10: the flag holds while no clear is requested
    p_flag_sticky_r10: assert property (@(posedge clk) disable iff (!rst_n)
        (flag && !clr) |=> flag);
    // R10: every pulse is accompanied by a set flag
    p_flag_with_pulse_r10: assert property (@(posedge clk) disable iff (!rst_n)
        pulse |-> flag);
endmodule

// File: rtl/stm_timer.sv
// Module: stm_timer (top)
// System timer with NUM_CH past-qualified compare channels on a shared
// 250 ns count. The count is re-alignable by a load strobe.
// Assumes the clock runs at TICK_DIV x 4 MHz so a tick is 250 ns.
module stm_timer
    import stm_pkg::*;
#(
    parameter int NUM_CH   = 4,
    parameter int CNT_W    = 32,
    parameter int TICK_DIV = 4,
    parameter int WIN_Q    = 4194304,
    parameter int WIN_US   = 4294967
) (
    input  logic                    clk,
    input  logic                    rst_n,
    input  logic                    sync_ld,
    input  logic [CNT_W-1:0]        sync_val,
    input  logic [NUM_CH-1:0]       cmp_wr,
    input  logic [NUM_CH-1:0]       cmp_us,
    input  logic [NUM_CH*CNT_W-1:0] cmp_tgt,
    input  logic [NUM_CH-1:0]       flag_clr,
    output logic [NUM_CH-1:0]       evt_pulse,
    output logic [NUM_CH-1:0]       evt_flag,
    output logic [CNT_W-1:0]        now_ticks
);
    logic tick;
    logic reeval;

    stm_tick_gen #(.TICK_DIV(TICK_DIV)) u_tick (
        .clk     (clk),
        .rst_n   (rst_n),
        .restart (sync_ld),
        .tick    (tick)
    );

    stm_counter #(.CNT_W(CNT_W)) u_count (
        .clk      (clk),
        .rst_n    (rst_n),
        .tick     (tick),
        .sync_ld  (sync_ld),
        .sync_val (sync_val),
        .count    (now_ticks),
        .reeval   (reeval)
    );

    generate
        for (genvar ch = 0; ch < NUM_CH; ch++) begin : g_ch
            stm_channel #(
                .CNT_W  (CNT_W),
                .WIN_Q  (WIN_Q),
                .WIN_US (WIN_US)
            ) u_ch (
                .clk    (clk),
                .rst_n  (rst_n),
                .now    (now_ticks),
                .reeval (reeval),
                .wr_en  (cmp_wr[ch]),
                .wr_us  (cmp_us[ch]),
                .wr_tgt (cmp_tgt[ch*CNT_W +: CNT_W]),
                .clr    (flag_clr[ch]),
                .pulse  (evt_pulse[ch]),
                .flag   (evt_flag[ch])
            );

            // R11: a channel with no write, no armed match path and no
            // re-evaluation keeps its flag unless it is cleared
            p_chan_isolated_r11: assert property (@(posedge clk) disable iff (!rst_n)
                (evt_flag[ch] && !flag_clr[ch]) |=> evt_flag[ch]);
        end
    endgenerate

    // R1: outputs are quiet on the first cycle after reset
    p_reset_quiet_r1: assert property (@(posedge clk)
        !rst_n |=> (evt_pulse == '0 && evt_flag == '0 && now_ticks == '0));
endmodule

// File: tb/stm_timer_tb.sv
module stm_timer_tb;
    localparam int NCH   = 4;
    localparam int CW    = 32;
    localparam int DIV   = 4;
    localparam int WQ    = 4194304;
    localparam int WU    = 4294967;
    localparam int LIMIT = 150000;

    logic            clk = 1'b0;
    logic            rst_n = 1'b0;
    logic            sync_ld = 1'b0;
    logic [CW-1:0]   sync_val = '0;
    logic [NCH-1:0]  cmp_wr = '0;
    logic [NCH-1:0]  cmp_us = '0;
    logic [NCH*CW-1:0] cmp_tgt = '0;
    logic [NCH-1:0]  flag_clr = '0;
    logic [NCH-1:0]  evt_pulse;
    logic [NCH-1:0]  evt_flag;
    logic [CW-1:0]   now_ticks;

    int checks = 0;
    int fails = 0;
    bit done = 1'b0;

    always #2.5 clk = ~clk;

    stm_timer #(.NUM_CH(NCH), .CNT_W(CW), .TICK_DIV(DIV), .WIN_Q(WQ), .WIN_US(WU)) u_dut (
        .clk(clk), .rst_n(rst_n), .sync_ld(sync_ld), .sync_val(sync_val),
        .cmp_wr(cmp_wr), .cmp_us(cmp_us), .cmp_tgt(cmp_tgt), .flag_clr(flag_clr),
        .evt_pulse(evt_pulse), .evt_flag(evt_flag), .now_ticks(now_ticks)
    );

    // Vector: unit (1 = us), signed offset from current count in that unit,
    // and whether the write falls inside the past window (fires next clock)
    typedef struct packed {
        logic        us;
        logic [31:0] ofs;
        logic        imm;
    } vec_t;

    localparam int NV = 10;
    localparam vec_t VECS [NV] = '{
        '{1'b0, 32'd0,            1'b1},
        '{1'b0, -32'd1,           1'b1},
        '{1'b0, -32'(WQ - 1),     1'b1},
        '{1'b0, -32'(WQ),         1'b0},
        '{1'b0, 32'd5,            1'b0},
        '{1'b1, 32'd0,            1'b1},
        '{1'b1, -32'd1,           1'b1},
        '{1'b1, -32'(WU - 1),     1'b1},
        '{1'b1, -32'(WU),         1'b0},
        '{1'b1, 32'd3,            1'b0}
    };

    task automatic check(input bit ok, input string req, input longint act, input longint exp);
        checks++;
        if (!ok) begin
            fails++;
            $display("FAIL %s: actual=%0h expected=%0h", req, act, exp);
        end
    endtask

    task automatic clear_all();
        @(negedge clk); flag_clr = '1;
        @(negedge clk); flag_clr = '0;
    endtask

    task automatic write_ch(input int ch, input logic us, input logic [31:0] t);
        cmp_wr[ch] = 1'b1; cmp_us[ch] = us; cmp_tgt[ch*CW +: CW] = t;
        @(negedge clk);
        cmp_wr = '0;
    endtask

    // Wait for a pulse on ch; returns the count seen one cycle before it
    task automatic wait_pulse(input int ch, input int maxc, output bit seen, output logic [31:0] prev);
        logic [31:0] last;
        seen = 1'b0; prev = '0; last = now_ticks;
        for (int k = 0; k < maxc; k++) begin
            @(negedge clk);
            if (evt_pulse[ch]) begin
                seen = 1'b1; prev = last;
                break;
            end
            last = now_ticks;
        end
    endtask

    initial begin
        #(LIMIT * 5);
        if (!done) begin
            fails++; checks++;
            $display("FAIL watchdog: actual=%0d expected=%0d", 1, 0);
            $display("%0d/%0d checks passed", checks - fails, checks);
            $finish;
        end
    end

    initial begin
        bit seen;
        logic [31:0] prev, n, t, v;
        int cnt;

        // R1: reset state
        repeat (3) @(negedge clk);
        check(now_ticks == 0, "R1 count", now_ticks, 0);
        check(evt_flag == 0 && evt_pulse == 0, "R1 outputs", {evt_flag, evt_pulse}, 0);
        rst_n = 1'b1;
        @(negedge clk);
        check(now_ticks == 0 && evt_flag == 0, "R1 after release", now_ticks, 0);

        // R2: spacing between count changes
        n = now_ticks;
        while (now_ticks == n) @(negedge clk);
        n = now_ticks; cnt = 0;
        while (now_ticks == n) begin @(negedge clk); cnt++; end
        check(cnt == DIV, "R2 tick spacing", cnt, DIV);
        check(now_ticks == n + 1, "R2 step", now_ticks, n + 1);

        // Vector table: R3/R4/R5/R6 across units and window edges
        for (int i = 0; i < NV; i++) begin
            int ch;
            ch = i % NCH;
            clear_all();
            n = now_ticks;
            if (VECS[i].us) t = (((n >> 2) + VECS[i].ofs) & 32'h3FFF_FFFF);
            else            t = n + VECS[i].ofs;
            write_ch(ch, VECS[i].us, t);
            check(evt_pulse[ch] == VECS[i].imm, VECS[i].us ? "R5 window" : "R4 window",
                  evt_pulse[ch], VECS[i].imm);
            if (!VECS[i].imm && VECS[i].ofs[31] == 1'b0) begin
                wait_pulse(ch, 200, seen, prev);
                v = VECS[i].us ? (t << 2) : t;
                check(seen && prev == v, "R6 R3 armed match", prev, v);
            end else if (!VECS[i].imm) begin
                repeat (30) @(negedge clk);
                check(evt_flag[ch] == 1'b0, "R6 far target stays armed", evt_flag[ch], 0);
            end
        end

        // R7: microsecond target matches four ticks but pulses once
        clear_all();
        t = (now_ticks >> 2) + 2;
        write_ch(0, 1'b1, t);
        cnt = 0;
        for (int k = 0; k < 60; k++) begin
            @(negedge clk);
            if (evt_pulse[0]) cnt++;
        end
        check(cnt == 1, "R7 one pulse", cnt, 1);

        // R10: flag sticky then cleared
        check(evt_flag[0] == 1'b1, "R10 flag sticky", evt_flag[0], 1);
        flag_clr[0] = 1'b1; @(negedge clk); flag_clr = '0;
        check(evt_flag[0] == 1'b0, "R10 flag cleared", evt_flag[0], 0);

        // R11: a fire on channel 1 leaves the others untouched
        clear_all();
        write_ch(1, 1'b0, now_ticks);
        @(negedge clk);
        check(evt_flag == 4'b0010, "R11 isolation", evt_flag, 4'b0010);

        // R8: load and restarted phase
        clear_all();
        sync_ld = 1'b1; sync_val = 32'h1234_5678;
        @(negedge clk); sync_ld = 1'b0;
        check(now_ticks == 32'h1234_5678, "R8 load", now_ticks, 32'h1234_5678);
        repeat (DIV - 1) @(negedge clk);
        check(now_ticks == 32'h1234_5678, "R8 phase hold", now_ticks, 32'h1234_5678);
        @(negedge clk);
        check(now_ticks == 32'h1234_5679, "R8 phase step", now_ticks, 32'h1234_5679);

        // R9: jump past ch2 target fires it; ch3 target still ahead
        clear_all();
        t = now_ticks + 1000;
        write_ch(2, 1'b0, t);
        write_ch(3, 1'b0, t + 1000);
        sync_ld = 1'b1; sync_val = t + 7;
        @(negedge clk); sync_ld = 1'b0;
        check(evt_pulse[2] == 1'b0 && now_ticks == t + 7, "R9 before reeval", evt_pulse[2], 0);
        @(negedge clk);
        check(evt_pulse[2] == 1'b1, "R9 reeval fire", evt_pulse[2], 1);
        check(evt_pulse[3] == 1'b0 && evt_flag[3] == 1'b0, "R9 ahead stays armed", evt_flag[3], 0);

        // R2/R3: target behind a wrapping count fires after the wrap
        clear_all();
        sync_ld = 1'b1; sync_val = 32'hFFFF_FFF0;
        @(negedge clk); sync_ld = 1'b0;
        write_ch(0, 1'b0, 32'h3);
        check(evt_pulse[0] == 1'b0, "R4 wrap not past", evt_pulse[0], 0);
        wait_pulse(0, 200, seen, prev);
        check(seen && prev == 32'h3, "R2 wrap fire", prev, 32'h3);

        done = 1'b1;
        $display("%0d/%0d checks passed", checks - fails, checks);
        $finish;
    end
endmodule